// File: doc/BRIEF.md
# Decoded Johnson Decade Counter

This block counts events in a ring of ten states and shows the current state as ten one-hot decoded lines. The state lives in a five-bit twisted-ring (Johnson) register. Each state is decoded from just two neighbouring bits, so every output is a two-input gate away from a flop. A terminal-count line is high for the first half of the cycle and low for the second half. It rises as the ring wraps from the last state back to state zero, so a cascaded stage can use it as its own count input.

Two asynchronous control inputs pass through two-flop synchronizers on a fast system clock: a count clock and an active-high inhibit. A count event is a rising edge of the count clock while the inhibit is low, or a falling edge of the inhibit while the count clock is high. An active-high master reset, taken on the system clock, forces state zero and overrides all counting.

Top module: `decade_johnson_counter`

## Requirements
- R1: The ring has exactly ten states. After ten count events from any state the decoded outputs return to that state, and state 9 advances to state 0.
- R2: Exactly one bit of `decOut` is high in every cycle after reset. Bit k high means count index k. On each count event the high bit moves from index k to index (k+1) mod 10.
- R3: A rising edge of `cntClk` while `inhibit` is low advances the count by one. The decoded outputs change on the third system-clock edge after the input changes.
- R4: A falling edge of `inhibit` while `cntClk` is high advances the count by one.
- R5: None of these changes the count: a falling edge of `cntClk`, a rising edge of `inhibit`, or a rising edge of `cntClk` while `inhibit` is high.
- R6: While `rstHi` is high, `decOut` is 10'b0000000001 (index 0) and `termCnt` is 1 from the next system-clock edge on, and no event advances the count.
- R7: `termCnt` is 1 for indices 0 to 4 and 0 for indices 5 to 9.
- R8: If a `cntClk` rise and an `inhibit` fall arrive in the same sample, the count advances only once.
- R9: Releasing reset while `cntClk` is held high produces no count event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all inputs |
| rstHi | input | 1 | Master reset, active high, synchronous to `clk` |
| cntClk | input | 1 | Asynchronous count clock |
| inhibit | input | 1 | Asynchronous active-high count inhibit |
| decOut | output | 10 | One-hot decoded count index |
| termCnt | output | 1 | High for indices 0 to 4, used to cascade stages |

## Verification
The checker watches the properties of every cycle. `decOut` stays one-hot. It only ever moves by a single rotation. It holds still unless the control raised an advance strobe. Reset forces index 0, and `termCnt` agrees with the lower half of the decoded lines. The checker cannot see which input patterns count and which do not, so the bench scenarios cover that. They cover count-clock rises with and without inhibit, inhibit falls with the count clock high, ignored falling edges, coincident events, the ten-state wrap, and reset release with the count clock held high.

// File: rtl/jdc_pkg.sv
package jdc_pkg;

  // Strobes passed from control to the datapath each system clock
  typedef struct packed {
    logic clear;    // force state zero
    logic advance;  // step the ring by one position
  } jdcStrobe_t;

endpackage

// File: rtl/jdc_control.sv
module jdc_control
  import jdc_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rstHi,
  input  logic       cntClk,
  input  logic       inhibit,
  output jdcStrobe_t strobe
);

  logic [SYNC_DEPTH-1:0] clkSync;
  logic [SYNC_DEPTH-1:0] inhSync;
  logic                  clkPrev;
  logic                  inhPrev;
  logic                  clkNow;
  logic                  inhNow;
  logic                  clkRise;
  logic                  inhFall;

  // Synchronizer chains run during reset too, so the history tracks
  // the inputs and no edge appears when reset is released.
  always_ff @(posedge clk) begin
    clkSync <= {clkSync[SYNC_DEPTH-2:0], cntClk};
    inhSync <= {inhSync[SYNC_DEPTH-2:0], inhibit};
    clkPrev <= clkSync[SYNC_DEPTH-1];
    inhPrev <= inhSync[SYNC_DEPTH-1];
  end

  assign clkNow  = clkSync[SYNC_DEPTH-1];
  assign inhNow  = inhSync[SYNC_DEPTH-1];
  assign clkRise = clkNow & ~clkPrev;
  assign inhFall = ~inhNow & inhPrev;

  always_comb begin
    strobe.clear   = rstHi;
    // Either condition gives one step; both together still give one.
    strobe.advance = ~rstHi & ((clkRise & ~inhNow) | (inhFall & clkNow));
  end

endmodule

// File: rtl/jdc_datapath.sv
module jdc_datapath
  import jdc_pkg::*;
#(
  parameter int STAGES = 5,
  localparam int OUTS = 2 * STAGES
) (
  input  logic            clk,
  input  jdcStrobe_t      strobe,
  output logic [OUTS-1:0] decOut,
  output logic            termCnt
);

  logic [STAGES-1:0] ring;
  logic [STAGES-1:0] ringNext;
  logic              ringLegal;

  // A legal twisted-ring code has at most one change between neighbours.
  always_comb begin
    int changes;
    changes = 0;
    for (int i = 0; i < STAGES - 1; i++) begin
      if (ring[i] != ring[i+1]) changes++;
    end
    ringLegal = (changes <= 1);
  end

  always_comb begin
    if (ringLegal) ringNext = {ring[STAGES-2:0], ~ring[STAGES-1]};
    else           ringNext = '0;
  end

  always_ff @(posedge clk) begin
    if (strobe.clear)        ring <= '0;
    else if (strobe.advance) ring <= ringNext;
  end

  // Each decoded line looks at two neighbouring ring bits.
  assign decOut[0]      = ~ring[STAGES-1] & ~ring[0];
  assign decOut[STAGES] =  ring[STAGES-1] &  ring[0];

  for (genvar k = 1; k < STAGES; k++) begin : g_fill
    assign decOut[k] = ring[k-1] & ~ring[k];
  end

  for (genvar k = STAGES + 1; k < OUTS; k++) begin : g_drain
    assign decOut[k] = ~ring[k-STAGES-1] & ring[k-STAGES];
  end

  assign termCnt = ~ring[STAGES-1];

endmodule

// File: rtl/decade_johnson_counter.sv
module decade_johnson_counter
  import jdc_pkg::*;
#(
  parameter int STAGES = 5,
  parameter int SYNC_DEPTH = 2,
  localparam int OUTS = 2 * STAGES
) (
  input  logic            clk,
  input  logic            rstHi,
  input  logic            cntClk,
  input  logic            inhibit,
  output logic [OUTS-1:0] decOut,
  output logic            termCnt
);

  jdcStrobe_t strobe;

  jdc_control #(.SYNC_DEPTH(SYNC_DEPTH)) u_ctrl (
    .clk     (clk),
    .rstHi   (rstHi),
    .cntClk  (cntClk),
    .inhibit (inhibit),
    .strobe  (strobe)
  );

  jdc_datapath #(.STAGES(STAGES)) u_dp (
    .clk     (clk),
    .strobe  (strobe),
    .decOut  (decOut),
    .termCnt (termCnt)
  );

endmodule

// File: rtl/jdc_checker.sv
module jdc_checker #(
  parameter int STAGES = 5,
  localparam int OUTS = 2 * STAGES
) (
  input logic            clk,
  input logic            rstHi,
  input logic            advance,
  input logic [OUTS-1:0] decOut,
  input logic            termCnt
);

  p_onehot_r2: assert property (@(posedge clk) disable iff (rstHi)
    $past(rstHi) || $onehot(decOut))
    else $error("decOut not one-hot");

  p_rotate_r2: assert property (@(posedge clk) disable iff (rstHi)
    !$stable(decOut) |-> decOut == {$past(decOut[OUTS-2:0]), $past(decOut[OUTS-1])})
    else $error("decOut moved other than by one position");

  p_hold_r5: assert property (@(posedge clk) disable iff (rstHi)
    !advance |=> $stable(decOut))
    else $error("decOut changed without an advance strobe");

  p_reset_r6: assert property (@(posedge clk)
    rstHi |=> (decOut == OUTS'(1)) && termCnt)
    else $error("reset did not force index 0");

  p_termcnt_r7: assert property (@(posedge clk) disable iff (rstHi)
    $past(rstHi) || (termCnt == (|decOut[STAGES-1:0])))
    else $error("termCnt disagrees with decoded index");

endmodule

bind decade_johnson_counter jdc_checker #(.STAGES(STAGES)) u_chk (
  .clk     (clk),
  .rstHi   (rstHi),
  .advance (strobe.advance),
  .decOut  (decOut),
  .termCnt (termCnt)
);

// File: tb/sim_decade_johnson_counter.sv
`timescale 1ns/1ps
module sim_decade_johnson_counter;

  logic       clk = 1'b0;
  logic       rstHi = 1'b1;
  logic       cntClk = 1'b0;
  logic       inhibit = 1'b0;
  logic [9:0] decOut;
  logic       termCnt;

  int checks = 0;
  int fails = 0;
  int expIdx = 0;

  always #2.5 clk = ~clk;

  decade_johnson_counter u0 (
    .clk(clk), .rstHi(rstHi), .cntClk(cntClk), .inhibit(inhibit),
    .decOut(decOut), .termCnt(termCnt)
  );

  task automatic chk(string tag, logic [9:0] act, logic [9:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, expv);
    end
  endtask

  // Compare outputs with the model index; termCnt follows R7.
  task automatic chkState(string tag);
    chk(tag, decOut, 10'(1) << expIdx);
    chk({tag, " R7 termCnt"}, {9'b0, termCnt}, {9'b0, (expIdx < 5)});
  endtask

  // Drive both inputs at a falling edge, then wait past the pipeline.
  task automatic drive(logic c, logic i);
    @(negedge clk);
    cntClk  = c;
    inhibit = i;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstHi = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    expIdx = 0;
    chkState("R6 reset state");
    @(negedge clk);
    rstHi = 1'b0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic testClockCount();
    drive(1'b0, 1'b0);
    for (int n = 0; n < 3; n++) begin
      drive(1'b1, 1'b0);
      expIdx = (expIdx + 1) % 10;
      chkState("R3 count-clock rise");
      drive(1'b0, 1'b0);
      chkState("R5 count-clock fall no change");
    end
  endtask

  task automatic testInhibit();
    drive(1'b0, 1'b1);
    chkState("R5 inhibit rise no change");
    drive(1'b1, 1'b1);
    chkState("R5 rise while inhibited ignored");
    drive(1'b1, 1'b0);
    expIdx = (expIdx + 1) % 10;
    chkState("R4 inhibit fall with count clock high");
    drive(1'b0, 1'b0);
    drive(1'b0, 1'b1);
    drive(1'b0, 1'b0);
    chkState("R4 inhibit fall with count clock low ignored");
  endtask

  task automatic testWrap();
    logic [9:0] start;
    start = decOut;
    for (int n = 0; n < 10; n++) begin
      drive(1'b1, 1'b0);
      expIdx = (expIdx + 1) % 10;
      chkState("R2 step through cycle");
      drive(1'b0, 1'b0);
    end
    chk("R1 ten events return to start", decOut, start);
  endtask

  task automatic testWrapFromNine();
    doReset();
    for (int n = 0; n < 9; n++) begin
      drive(1'b1, 1'b0);
      drive(1'b0, 1'b0);
    end
    expIdx = 9;
    chkState("R7 index 9");
    drive(1'b1, 1'b0);
    expIdx = 0;
    chkState("R1 wrap 9 to 0");
  endtask

  task automatic testCoincident();
    drive(1'b0, 1'b1);
    drive(1'b1, 1'b0);
    expIdx = (expIdx + 1) % 10;
    chkState("R8 coincident events count once");
    drive(1'b0, 1'b0);
  endtask

  task automatic testResetOverride();
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
    @(negedge clk);
    rstHi = 1'b1;
    cntClk = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    expIdx = 0;
    chkState("R6 no count while reset");
    @(negedge clk);
    rstHi = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    chkState("R9 release with count clock high");
    drive(1'b0, 1'b0);
    chkState("R9 later fall no change");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chkState("R6 power-on reset");
    @(negedge clk);
    rstHi = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    testClockCount();
    testInhibit();
    testWrap();
    testWrapFromNine();
    testCoincident();
    testResetOverride();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule